// File: doc/BRIEF.md
# Reset and Halt Bus Sequencer

This block sits on the processor side of a system bus. It watches the active-low RESET and HALT lines and controls when word-wide bus cycles may run on a simple request/acknowledge memory port. A system reset counts only when both lines have been held low together for a qualification window, given in clock cycles. When both lines are released after such a hold, the block runs a start-up fetch. It reads a 32-bit initial stack pointer, then a 32-bit initial program counter, from the lowest addresses of memory. Each vector takes two 16-bit reads, upper half first.

Once started, the block passes bus cycles from the core to memory. Holding HALT low stops the block after the bus cycle in progress, and the address and data buses are released. While HALT stays low, each brief release (one clock) followed by reassertion lets exactly one more bus cycle complete. This gives cycle-by-cycle stepping. A longer release resumes normal running. The block can pull RESET low to reset the rest of the system without resetting itself, and it can pull HALT low to report an error. Each pin is split into a sensed input, a driven value and a drive enable.

Top module: `rst_halt_seq`

## Requirements
- R1: A start-up fetch begins only when RESET and HALT were both sampled low together on at least QUAL_CYCLES consecutive clock edges and are then both released. A shorter common hold, or RESET held low alone, leaves the fetch counter and the loaded vectors unchanged.
- R2: The start-up fetch issues four read cycles (mem_we = 0) at byte addresses 0, 2, 4 and 6, in that order. The words from 0 and 2 form init_sp, upper half first. The words from 4 and 6 form init_pc. boot_done goes high after the fourth read completes.
- R3: When HALT is asserted, the bus cycle in progress still completes, and no new cycle starts while HALT stays asserted.
- R4: bus_oe is high whenever mem_req is high. bus_oe is low whenever HALT is sampled asserted and no cycle is in progress.
- R5: While HALT is asserted, a release lasting one clock followed by reassertion allows exactly one further bus cycle. A release of many clocks resumes free-running cycles.
- R6: mem_req stays high, with mem_addr and mem_we stable, until mem_ack. During normal running, core_ack pulses with core_rdata equal to the word that memory returned for core_addr.
- R7: While err_halt is high, the block drives HALT low (halt_pin_oe = 1, halt_pin_out = 0), and no new bus cycle starts.
- R8: While sys_reset_req is high, the block drives RESET low (reset_pin_oe = 1, reset_pin_out = 0). The block itself keeps running, with no new start-up fetch.
- R9: From power-on until the first qualified reset, no bus cycle runs, bus_oe is low and boot_done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset of the block's own registers, active low |
| reset_pin_in | input | 1 | Sensed level of the RESET line (low = asserted) |
| reset_pin_out | output | 1 | Value driven onto RESET when enabled (always low) |
| reset_pin_oe | output | 1 | Drive enable for RESET |
| halt_pin_in | input | 1 | Sensed level of the HALT line (low = asserted) |
| halt_pin_out | output | 1 | Value driven onto HALT when enabled (always low) |
| halt_pin_oe | output | 1 | Drive enable for HALT |
| sys_reset_req | input | 1 | Core request to reset the other devices |
| err_halt | input | 1 | Core request to signal an error on HALT |
| core_req | input | 1 | Core bus cycle request, held until core_ack |
| core_we | input | 1 | Core cycle is a write |
| core_addr | input | AW | Core byte address |
| core_wdata | input | DW | Core write data |
| core_ack | output | 1 | Core cycle completed |
| core_rdata | output | DW | Read data returned to the core |
| mem_req | output | 1 | Memory cycle in progress |
| mem_we | output | 1 | Memory cycle is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory completes the current cycle |
| mem_rdata | input | DW | Memory read data |
| bus_oe | output | 1 | Address and data buses are driven |
| boot_done | output | 1 | Start-up fetch finished, normal running |
| init_sp | output | VW | Loaded initial stack pointer |
| init_pc | output | VW | Loaded initial program counter |

## Verification
The bench sweeps the common RESET/HALT hold length across the qualification boundary, from well above it down to one clock. A block that counted one cycle too few or too many would start a fetch one step early or late, and one that ignored the hold time would refetch on every short pulse. It asserts HALT in the middle of a bus cycle. A block that aborted the cycle would lose one acknowledge, and one that checked HALT too late would run an extra cycle. It gives repeated one-clock HALT releases, where a block that mishandled edges would step zero or two cycles per pulse. It also checks that its own RESET drive and error HALT drive do not restart the fetch, and that cycles stop while the error HALT is driven.

// File: rtl/rsh_pkg.sv
package rsh_pkg;

  typedef enum logic [1:0] {
    SEQ_WAIT = 2'd0,
    SEQ_BOOT = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_state_e;

  // Byte address of the idx-th word of the start-up fetch.
  function automatic logic [31:0] fetch_addr(input int idx, input int bytes_per_word);
    return 32'(idx * bytes_per_word);
  endfunction

endpackage

// File: rtl/rsh_qual.sv
module rsh_qual #(
  parameter int QUAL_CYCLES = 5_000_000
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_asserted,
  input  logic halt_asserted,
  output logic qual_done,
  output logic boot_fire
);
  localparam int CW = $clog2(QUAL_CYCLES + 1);

  logic [CW-1:0] hold_cnt_q;
  logic          both_low;

  assign both_low  = rst_asserted & halt_asserted;
  assign qual_done = (hold_cnt_q == CW'(QUAL_CYCLES));
  assign boot_fire = qual_done & ~rst_asserted & ~halt_asserted;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      hold_cnt_q <= '0;
    end else if (both_low) begin
      if (!qual_done) hold_cnt_q <= hold_cnt_q + 1'b1;
    end else begin
      hold_cnt_q <= '0;
    end
  end
endmodule

// File: rtl/rsh_step.sv
module rsh_step (
  input  logic clk,
  input  logic por_n,
  input  logic halt_pin_in,
  input  logic cycle_start,
  output logic halt_asserted,
  output logic run_ok,
  output logic step_credit
);
  logic h1_q, h2_q, h3_q;
  logic credit_q;
  logic short_fall;

  // Three samples of the HALT level: a high lasting exactly one sample,
  // followed by a low, is a step pulse.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      h1_q <= 1'b1;
      h2_q <= 1'b1;
      h3_q <= 1'b1;
    end else begin
      h1_q <= halt_pin_in;
      h2_q <= h1_q;
      h3_q <= h2_q;
    end
  end

  assign halt_asserted = ~h1_q;
  assign run_ok        = h1_q & h2_q;
  assign short_fall    = ~h1_q & h2_q & ~h3_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)           credit_q <= 1'b0;
    else if (run_ok)      credit_q <= 1'b0;
    else if (short_fall)  credit_q <= 1'b1;
    else if (cycle_start) credit_q <= 1'b0;
  end

  assign step_credit = credit_q;
endmodule

// File: rtl/rst_halt_seq.sv
module rst_halt_seq
  import rsh_pkg::*;
#(
  parameter int AW          = 24,
  parameter int DW          = 16,
  parameter int VW          = 32,
  parameter int QUAL_CYCLES = 5_000_000
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          reset_pin_in,
  output logic          reset_pin_out,
  output logic          reset_pin_oe,
  input  logic          halt_pin_in,
  output logic          halt_pin_out,
  output logic          halt_pin_oe,
  input  logic          sys_reset_req,
  input  logic          err_halt,
  input  logic          core_req,
  input  logic          core_we,
  input  logic [AW-1:0] core_addr,
  input  logic [DW-1:0] core_wdata,
  output logic          core_ack,
  output logic [DW-1:0] core_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          bus_oe,
  output logic          boot_done,
  output logic [VW-1:0] init_sp,
  output logic [VW-1:0] init_pc
);
  localparam int WPV    = VW / DW;
  localparam int NFETCH = 2 * WPV;
  localparam int IDX_W  = (NFETCH > 1) ? $clog2(NFETCH) : 1;
  localparam int BPW    = DW / 8;

  seq_state_e        state_q;
  logic              busy_q;
  logic [IDX_W-1:0]  idx_q;
  logic [AW-1:0]     addr_q;
  logic              we_q;
  logic [DW-1:0]     wdata_q;
  logic [2*VW-1:0]   vecs_q;
  logic              rst_asserted_q;

  logic halt_asserted, run_ok, step_credit;
  logic qual_done, boot_fire;
  logic in_boot, in_run, in_wait;
  logic src_req, allow, cycle_start, cycle_done;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) rst_asserted_q <= 1'b0;
    else        rst_asserted_q <= ~reset_pin_in;
  end

  rsh_step u_step (
    .clk          (clk),
    .por_n        (por_n),
    .halt_pin_in  (halt_pin_in),
    .cycle_start  (cycle_start),
    .halt_asserted(halt_asserted),
    .run_ok       (run_ok),
    .step_credit  (step_credit)
  );

  rsh_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk          (clk),
    .por_n        (por_n),
    .rst_asserted (rst_asserted_q),
    .halt_asserted(halt_asserted),
    .qual_done    (qual_done),
    .boot_fire    (boot_fire)
  );

  assign in_boot     = (state_q == SEQ_BOOT);
  assign in_run      = (state_q == SEQ_RUN);
  assign in_wait     = (state_q == SEQ_WAIT);
  assign src_req     = in_boot | (in_run & core_req);
  assign allow       = run_ok | step_credit;
  assign cycle_start = ~busy_q & src_req & allow & ~boot_fire & ~err_halt;
  assign cycle_done  = busy_q & mem_ack;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state_q <= SEQ_WAIT;
      busy_q  <= 1'b0;
      idx_q   <= '0;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      vecs_q  <= '0;
    end else if (boot_fire) begin
      state_q <= SEQ_BOOT;
      busy_q  <= 1'b0;
      idx_q   <= '0;
      vecs_q  <= '0;
    end else begin
      if (cycle_start) begin
        busy_q <= 1'b1;
        if (in_boot) begin
          addr_q  <= AW'(fetch_addr(int'(idx_q), BPW));
          we_q    <= 1'b0;
          wdata_q <= '0;
        end else begin
          addr_q  <= core_addr;
          we_q    <= core_we;
          wdata_q <= core_wdata;
        end
      end
      if (cycle_done) begin
        busy_q <= 1'b0;
        if (in_boot) begin
          vecs_q <= {vecs_q[2*VW-DW-1:0], mem_rdata};
          idx_q  <= idx_q + 1'b1;
          if (idx_q == IDX_W'(NFETCH - 1)) state_q <= SEQ_RUN;
        end
      end
    end
  end

  assign mem_req    = busy_q;
  assign mem_we     = we_q;
  assign mem_addr   = addr_q;
  assign mem_wdata  = wdata_q;
  assign core_ack   = cycle_done & in_run;
  assign core_rdata = mem_rdata;
  assign bus_oe     = busy_q | (in_run & run_ok);
  assign boot_done  = in_run;
  assign init_sp    = vecs_q[2*VW-1:VW];
  assign init_pc    = vecs_q[VW-1:0];

  assign reset_pin_out = 1'b0;
  assign reset_pin_oe  = sys_reset_req;
  assign halt_pin_out  = 1'b0;
  assign halt_pin_oe   = err_halt;
endmodule

// File: rtl/rsh_chk.sv
module rsh_chk #(
  parameter int AW       = 24,
  parameter int VEC_SPAN = 8
) (
  input logic          clk,
  input logic          por_n,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          bus_oe,
  input logic          halt_asserted,
  input logic          allow,
  input logic          in_boot,
  input logic          in_wait,
  input logic          qual_done,
  input logic          err_halt,
  input logic          halt_pin_oe,
  input logic          halt_pin_out
);
  assert_boot_after_qual_R1: assert property (@(posedge clk) disable iff (!por_n)
    $rose(in_boot) |-> $past(qual_done));

  assert_boot_reads_low_R2: assert property (@(posedge clk) disable iff (!por_n)
    (mem_req && in_boot) |-> (!mem_we && mem_addr < AW'(VEC_SPAN)));

  assert_no_start_halted_R3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(mem_req) |-> $past(allow));

  assert_drive_in_cycle_R4: assert property (@(posedge clk) disable iff (!por_n)
    mem_req |-> bus_oe);

  assert_float_halted_R4: assert property (@(posedge clk) disable iff (!por_n)
    (!mem_req && halt_asserted) |-> !bus_oe);

  assert_hold_until_ack_R6: assert property (@(posedge clk) disable iff (!por_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_err_drive_R7: assert property (@(posedge clk) disable iff (!por_n)
    err_halt |-> (halt_pin_oe && !halt_pin_out));

  assert_idle_before_boot_R9: assert property (@(posedge clk) disable iff (!por_n)
    in_wait |-> (!mem_req && !bus_oe));
endmodule

bind rst_halt_seq rsh_chk #(.AW(AW), .VEC_SPAN(2 * VW / 8)) u_chk (
  .clk          (clk),
  .por_n        (por_n),
  .mem_req      (mem_req),
  .mem_ack      (mem_ack),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .bus_oe       (bus_oe),
  .halt_asserted(halt_asserted),
  .allow        (allow),
  .in_boot      (in_boot),
  .in_wait      (in_wait),
  .qual_done    (qual_done),
  .err_halt     (err_halt),
  .halt_pin_oe  (halt_pin_oe),
  .halt_pin_out (halt_pin_out)
);

// File: tb/tb_rst_halt_seq.sv
`timescale 1ns/1ps
module tb_rst_halt_seq;
  localparam int AW = 24, DW = 16, VW = 32, QUAL = 6, LAT = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic por_n, ext_rst_low, ext_halt_low, sys_reset_req, err_halt;
  logic core_req, core_we;
  logic [AW-1:0] core_addr;
  logic [DW-1:0] core_wdata, core_rdata, mem_wdata, mem_rdata;
  logic core_ack, mem_req, mem_we, mem_ack, bus_oe, boot_done;
  logic [AW-1:0] mem_addr;
  logic [VW-1:0] init_sp, init_pc;
  logic reset_pin_out, reset_pin_oe, halt_pin_out, halt_pin_oe;
  logic reset_line, halt_line;

  assign reset_line = (ext_rst_low  | (reset_pin_oe & ~reset_pin_out)) ? 1'b0 : 1'b1;
  assign halt_line  = (ext_halt_low | (halt_pin_oe  & ~halt_pin_out))  ? 1'b0 : 1'b1;

  rst_halt_seq #(.AW(AW), .DW(DW), .VW(VW), .QUAL_CYCLES(QUAL)) dut (
    .clk(clk), .por_n(por_n),
    .reset_pin_in(reset_line), .reset_pin_out(reset_pin_out), .reset_pin_oe(reset_pin_oe),
    .halt_pin_in(halt_line), .halt_pin_out(halt_pin_out), .halt_pin_oe(halt_pin_oe),
    .sys_reset_req(sys_reset_req), .err_halt(err_halt),
    .core_req(core_req), .core_we(core_we), .core_addr(core_addr), .core_wdata(core_wdata),
    .core_ack(core_ack), .core_rdata(core_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .bus_oe(bus_oe), .boot_done(boot_done), .init_sp(init_sp), .init_pc(init_pc)
  );

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return {a[7:0] ^ 8'h5A, a[7:0] + 8'h33};
  endfunction

  // Memory model: acknowledges LAT edges after a request is seen.
  int acks = 0;
  int wcnt = 0;
  logic [AW-1:0] log_a [0:255];
  logic          log_we[0:255];
  always @(posedge clk) begin
    if (!mem_req || mem_ack) begin
      mem_ack <= 1'b0;
      wcnt <= 0;
    end else if (wcnt == LAT - 1) begin
      mem_ack <= 1'b1;
      mem_rdata <= mem_word(mem_addr);
      log_a[acks[7:0]] <= mem_addr;
      log_we[acks[7:0]] <= mem_we;
      acks <= acks + 1;
    end else begin
      wcnt <= wcnt + 1;
    end
  end

  // Core model: checks returned data, then moves to the next address.
  always @(posedge clk) begin
    if (core_ack) begin
      chk(core_rdata == mem_word(core_addr), "R6 core_rdata", core_rdata, mem_word(core_addr));
      core_addr <= core_addr + 2;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hold_both(input int n);
    @(negedge clk);
    ext_rst_low = 1'b1; ext_halt_low = 1'b1;
    repeat (n) @(negedge clk);
    ext_rst_low = 1'b0; ext_halt_low = 1'b0;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    summary();
  end

  initial begin
    int a0;
    logic [VW-1:0] sp_exp, pc_exp, sp0;
    mem_ack = 1'b0; mem_rdata = '0;
    por_n = 1'b0; ext_rst_low = 1'b0; ext_halt_low = 1'b0;
    sys_reset_req = 1'b0; err_halt = 1'b0;
    core_req = 1'b0; core_we = 1'b0; core_addr = 24'h000100; core_wdata = '0;
    sp_exp = {mem_word(24'd0), mem_word(24'd2)};
    pc_exp = {mem_word(24'd4), mem_word(24'd6)};
    cycles(3);
    chk(!mem_req && !bus_oe && !boot_done, "R9 reset state", {mem_req, bus_oe, boot_done}, 0);
    chk(!reset_pin_oe && !halt_pin_oe, "R9 pins idle", {reset_pin_oe, halt_pin_oe}, 0);
    por_n = 1'b1;
    cycles(20);
    chk(acks == 0 && !boot_done && !bus_oe, "R9 no cycles before qualified reset", acks, 0);

    // Hold-length sweep across the qualification boundary, longest first.
    for (int n = QUAL + 2; n >= 1; n--) begin
      a0 = acks;
      sp0 = init_sp;
      hold_both(n);
      cycles(40);
      if (n >= QUAL) begin
        chk(acks - a0 == 4, "R1 qualified hold fetches", acks - a0, 4);
        for (int i = 0; i < 4; i++) begin
          chk(log_a[8'(a0 + i)] == AW'(2 * i) && !log_we[8'(a0 + i)], "R2 fetch order",
              log_a[8'(a0 + i)], 2 * i);
        end
        chk(init_sp == sp_exp, "R2 init_sp", init_sp, sp_exp);
        chk(init_pc == pc_exp, "R2 init_pc", init_pc, pc_exp);
        chk(boot_done, "R2 boot_done", boot_done, 1);
      end else begin
        chk(acks - a0 == 0, "R1 short hold ignored", acks - a0, 0);
        chk(boot_done && init_sp == sp0, "R1 vectors kept", init_sp, sp0);
      end
    end

    // RESET alone held long.
    a0 = acks;
    @(negedge clk); ext_rst_low = 1'b1;
    cycles(QUAL + 4);
    ext_rst_low = 1'b0;
    cycles(40);
    chk(acks == a0 && boot_done, "R1 reset alone ignored", acks - a0, 0);

    // Own RESET drive.
    a0 = acks;
    sys_reset_req = 1'b1;
    cycles(3);
    chk(reset_line == 1'b0 && reset_pin_oe, "R8 reset driven low", reset_line, 0);
    cycles(10);
    sys_reset_req = 1'b0;
    cycles(40);
    chk(acks == a0 && boot_done, "R8 no self restart", acks - a0, 0);

    // Free running core cycles.
    core_req = 1'b1;
    a0 = acks;
    cycles(40);
    chk(acks - a0 >= 6, "R6 free running cycles", acks - a0, 6);

    // HALT in the middle of a cycle.
    @(negedge clk);
    while (!(mem_req && !mem_ack)) @(negedge clk);
    a0 = acks;
    ext_halt_low = 1'b1;
    cycles(30);
    chk(acks - a0 == 1, "R3 in-progress cycle completes only", acks - a0, 1);
    chk(!mem_req, "R3 no new cycle", mem_req, 0);
    chk(!bus_oe, "R4 buses floated while halted", bus_oe, 0);

    // Single-step pulses.
    for (int k = 0; k < 3; k++) begin
      a0 = acks;
      ext_halt_low = 1'b0;
      @(negedge clk);
      ext_halt_low = 1'b1;
      cycles(20);
      chk(acks - a0 == 1, "R5 one cycle per step", acks - a0, 1);
      chk(!bus_oe, "R4 floated after step", bus_oe, 0);
    end

    // Long release resumes running.
    a0 = acks;
    ext_halt_low = 1'b0;
    cycles(30);
    chk(acks - a0 >= 4, "R5 long release runs", acks - a0, 4);

    // Error HALT drive.
    err_halt = 1'b1;
    cycles(2);
    chk(halt_line == 1'b0 && halt_pin_oe, "R7 halt driven low", halt_line, 0);
    cycles(10);
    a0 = acks;
    cycles(20);
    chk(acks == a0, "R7 cycles stopped", acks - a0, 0);
    err_halt = 1'b0;
    a0 = acks;
    cycles(30);
    chk(acks - a0 >= 3, "R7 resume after error", acks - a0, 3);

    core_req = 1'b0;
    cycles(10);
    summary();
  end
endmodule